// File: doc/BRIEF.md
# Power Partition Gating Controller

This block switches individual power partitions on and off and releases the isolation clamps on their outputs. Software uses a small register bus. A command register inverts the power state of one partition. A status register shows which partitions are powered. A write-one register releases clamps. Each partition has an external power switch. The controller drives a request level to the switch and waits for the switch to return an acknowledge of the same level. The acknowledge passes through a synchroniser. After it matches, a settle interval must run out before the status bit changes.

Only one switch handshake runs at a time. If the switch does not answer within a bounded number of cycles, the controller gives up. It withdraws the request and leaves the status bit as it was. Turning a partition off raises its clamp again at once, so every later power-up starts clamped. The clamp-release bits of two partitions are exchanged, for compatibility with existing software. The two positions are parameters.

Top module: `pwr_part_gate`

## Requirements
- R1: After reset every power request is 0, every clamp output is 1 (clamped), and the status register reads 0.
- R2: A write to offset 0x30 with bit 8 set, while no handshake is running, inverts the power request of the partition named in bits [3:0]. The new request appears on the next clock.
- R3: A write to offset 0x30 with bit 8 clear changes no request and no status bit.
- R4: The status register at offset 0x38 holds bit n = 1 when partition n is powered, and its upper bits are 0. A bit takes its new value only after the switch acknowledge has matched the request and a further SETTLE_CYC cycles have passed. It never changes before the acknowledge.
- R5: While a handshake is running, command writes to any partition are ignored.
- R6: If the acknowledge does not match within TIMEOUT_CYC cycles of the command, the request returns to its old level and the status bit does not change. The controller then accepts new commands.
- R7: A write to offset 0x34 releases clamps, one bit per partition. A 1 in bit n releases partition n. Bits SWAP_A (default 3) and SWAP_B (default 4) release each other's partition. Bits written as 0 have no effect.
- R8: A clamp release for a partition that is not powered, or is being switched off, is ignored.
- R9: Accepting a power-off command sets the partition's clamp to 1 on the next clock. The clamp stays at 1 through the next power-up.
- R10: Read data appears one cycle after the read. Reads of offsets other than 0x38 (including 0x30 and 0x34) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busEn | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid the cycle after a read |
| swAck | input | NUM_PART | Power switch acknowledge levels (asynchronous) |
| pwrReq | output | NUM_PART | Power request level per partition |
| clampOn | output | NUM_PART | Isolation clamp per partition, 1 = clamped |

## Verification
Command and clamp writes take effect at the edge that samples them. The bench therefore checks `pwrReq` and `clampOn` at the falling edge right after each write. Read data is registered, so a queued expected value is compared one falling edge after the read. A status change is due after the acknowledge delay, plus two synchroniser stages, plus the settle interval. The bench reads the status once just after a command, when the old value must still hold. It reads again after a fixed margin that covers the whole chain. The timeout case is read only after the full timeout window plus a margin.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int IDX_MAX_W = 8;

  // register offsets: software depends on these positions
  localparam logic [7:0] OFF_TOGGLE = 8'h30;
  localparam logic [7:0] OFF_UNCLAMP = 8'h34;
  localparam logic [7:0] OFF_STATUS = 8'h38;
  localparam int START_BIT = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETTLE
  } ppg_state_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic flip;
    logic commit;
    logic abort;
    logic [IDX_MAX_W-1:0] idx;
  } ppg_strobe_t;
endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
  import ppg_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SETTLE_CYC = 8,
  parameter int TIMEOUT_CYC = 1250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic tglValid,
  input  logic [IDX_W-1:0] tglIdx,
  input  logic ackMatch,
  output logic [IDX_W-1:0] curIdx,
  output ppg_strobe_t strb
);
  localparam int MAX_CYC = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_TO = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_ST = CNT_W'(SETTLE_CYC - 1);

  ppg_state_e state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strb = '0;
    strb.idx = IDX_MAX_W'(curIdx);
    unique case (state)
      ST_IDLE: begin
        if (tglValid) begin
          strb.flip = 1'b1;
          strb.idx = IDX_MAX_W'(tglIdx);
        end
      end
      ST_WAIT: begin
        if (!ackMatch && cnt == LAST_TO) strb.abort = 1'b1;
      end
      ST_SETTLE: begin
        if (cnt == LAST_ST) strb.commit = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt <= '0;
      curIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (tglValid) begin
            curIdx <= tglIdx;
            cnt <= '0;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ackMatch) begin
            cnt <= '0;
            state <= ST_SETTLE;
          end else if (cnt == LAST_TO) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (cnt == LAST_ST) state <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (cnt <= LAST_TO)); // R6
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strb.flip); // R5
  AST_COMMIT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> ackMatch); // R4
endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath
  import ppg_pkg::*;
#(
  parameter int NUM_PART = 16,
  parameter int IDX_W = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SWAP_A = 3,
  parameter int SWAP_B = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic busEn,
  input  logic busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_PART-1:0] swAck,
  output logic [NUM_PART-1:0] pwrReq,
  output logic [NUM_PART-1:0] clampOn,
  input  ppg_strobe_t strb,
  input  logic [IDX_W-1:0] curIdx,
  output logic tglValid,
  output logic [IDX_W-1:0] tglIdx,
  output logic ackMatch
);
  logic [NUM_PART-1:0] status;
  logic [NUM_PART-1:0] ackSync;
  logic [NUM_PART-1:0] relMask;
  logic [NUM_PART-1:0] clampNext;
  logic wrEn, rdEn, unclampWr;
  logic [IDX_W-1:0] sIdx;

  assign wrEn = busEn && busWr;
  assign rdEn = busEn && !busWr;
  assign unclampWr = wrEn && (busAddr == ADDR_W'(OFF_UNCLAMP));
  assign tglIdx = busWdata[IDX_W-1:0];
  assign tglValid = wrEn && (busAddr == ADDR_W'(OFF_TOGGLE)) && busWdata[START_BIT]
                    && (int'(tglIdx) < NUM_PART);
  assign sIdx = strb.idx[IDX_W-1:0];

  // acknowledge synchroniser
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign ackSync = swAck;
    end else begin : g_sync
      logic [NUM_PART-1:0] syncQ [SYNC_STAGES];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '0;
        end else begin
          syncQ[0] <= swAck;
          for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
        end
      end
      assign ackSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  assign ackMatch = (ackSync[curIdx] == pwrReq[curIdx]);

  // clamp-release bit routing, two positions exchanged
  generate
    for (genvar p = 0; p < NUM_PART; p++) begin : g_rel
      localparam int SRC = (p == SWAP_A) ? SWAP_B : ((p == SWAP_B) ? SWAP_A : p);
      assign relMask[p] = unclampWr && busWdata[SRC];
    end
  endgenerate

  always_comb begin
    clampNext = clampOn & ~(relMask & status & pwrReq);
    if (strb.flip && pwrReq[sIdx]) clampNext[sIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrReq <= '0;
      status <= '0;
      clampOn <= '1;
      busRdata <= '0;
    end else begin
      clampOn <= clampNext;
      if (strb.flip) pwrReq[sIdx] <= ~pwrReq[sIdx];
      if (strb.abort) pwrReq[sIdx] <= status[sIdx];
      if (strb.commit) status[sIdx] <= pwrReq[sIdx];
      busRdata <= (rdEn && busAddr == ADDR_W'(OFF_STATUS)) ? DATA_W'(status) : '0;
    end
  end

  AST_SINGLE_INFLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pwrReq ^ status) <= 1); // R5
  AST_CLAMP_WHEN_UNREQ: assert property (@(posedge clk) disable iff (!rstN)
    (clampOn | pwrReq) == '1); // R9
  AST_RELEASE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    (~clampOn & ~status) == '0); // R8
  AST_REQ_BY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrReq != $past(pwrReq)) |-> $past(strb.flip || strb.abort)); // R2
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> (busRdata == '0)); // R10
endmodule

// File: rtl/pwr_part_gate.sv
module pwr_part_gate
  import ppg_pkg::*;
#(
  parameter int NUM_PART = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC = 8,
  parameter int TIMEOUT_CYC = 1250000,
  parameter int SWAP_A = 3,
  parameter int SWAP_B = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic busEn,
  input  logic busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_PART-1:0] swAck,
  output logic [NUM_PART-1:0] pwrReq,
  output logic [NUM_PART-1:0] clampOn
);
  localparam int IDX_W = (NUM_PART > 1) ? $clog2(NUM_PART) : 1;

  ppg_strobe_t strb;
  logic tglValid;
  logic [IDX_W-1:0] tglIdx;
  logic [IDX_W-1:0] curIdx;
  logic ackMatch;

  ppg_ctrl #(
    .IDX_W(IDX_W),
    .SETTLE_CYC(SETTLE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .tglValid(tglValid),
    .tglIdx(tglIdx),
    .ackMatch(ackMatch),
    .curIdx(curIdx),
    .strb(strb)
  );

  ppg_datapath #(
    .NUM_PART(NUM_PART),
    .IDX_W(IDX_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES),
    .SWAP_A(SWAP_A),
    .SWAP_B(SWAP_B)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .busEn(busEn),
    .busWr(busWr),
    .busAddr(busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .swAck(swAck),
    .pwrReq(pwrReq),
    .clampOn(clampOn),
    .strb(strb),
    .curIdx(curIdx),
    .tglValid(tglValid),
    .tglIdx(tglIdx),
    .ackMatch(ackMatch)
  );
endmodule

// File: tb/sim_pwr_part_gate.sv
module sim_pwr_part_gate;
  localparam int NP = 16;
  localparam int ACK_DLY = 5;
  localparam int WAIT_DONE = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busEn = 1'b0;
  logic busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NP-1:0] ackR;
  logic [NP-1:0] stuck = '0;
  logic [NP-1:0] pwrReq;
  logic [NP-1:0] clampOn;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  logic rdPend;
  logic [31:0] expQ[$];
  string tagQ[$];
  int ackCnt [NP];

  always #10 clk = ~clk;

  pwr_part_gate #(
    .NUM_PART(NP), .ADDR_W(8), .DATA_W(32), .SYNC_STAGES(2),
    .SETTLE_CYC(4), .TIMEOUT_CYC(30), .SWAP_A(3), .SWAP_B(4)
  ) u0 (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .swAck(ackR), .pwrReq(pwrReq), .clampOn(clampOn)
  );

  // switch model: acknowledge follows the request after ACK_DLY cycles
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackR <= '0;
      for (int i = 0; i < NP; i++) ackCnt[i] <= 0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (ackR[i] != pwrReq[i] && !stuck[i]) begin
          if (ackCnt[i] == ACK_DLY - 1) begin
            ackR[i] <= pwrReq[i];
            ackCnt[i] <= 0;
          end else ackCnt[i] <= ackCnt[i] + 1;
        end else ackCnt[i] <= 0;
      end
    end
  end

  always @(posedge clk) rdPend <= busEn && !busWr;

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (rdPend && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (busRdata !== e) begin
        nFails++;
        $display("FAIL %s: read data %h expected %h", t, busRdata, e);
      end
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busEn = 1'b1; busWr = 1'b0; busAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    busEn = 1'b0;
  endtask

  task automatic checkVec(input string t, input logic [NP-1:0] act, input logic [NP-1:0] e);
    nChecks++;
    if (act !== e) begin
      nFails++;
      $display("FAIL %s: value %h expected %h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkVec("R1 pwrReq", pwrReq, 16'h0000);
    checkVec("R1 clampOn", clampOn, 16'hFFFF);
    busRead(8'h38, 32'h0, "R1 status");
    // R10 unmapped and write-only offsets
    busRead(8'h30, 32'h0, "R10 toggle offset");
    busRead(8'h34, 32'h0, "R10 unclamp offset");
    busRead(8'h3C, 32'h0, "R10 offset 3C");
    busRead(8'h00, 32'h0, "R10 offset 00");
    // R2 toggle partition 1
    busWrite(8'h30, 32'h101);
    checkVec("R2 request flips", pwrReq, 16'h0002);
    busRead(8'h38, 32'h0, "R4 status before ack");
    // R5 command while busy is ignored
    busWrite(8'h30, 32'h102);
    checkVec("R5 busy command ignored", pwrReq, 16'h0002);
    idle(WAIT_DONE);
    busRead(8'h38, 32'h0002, "R4 status after settle");
    checkVec("R5 partition 2 stays off", pwrReq, 16'h0002);
    // R3 no start flag
    busWrite(8'h30, 32'h006);
    checkVec("R3 request unchanged", pwrReq, 16'h0002);
    idle(WAIT_DONE);
    busRead(8'h38, 32'h0002, "R3 status unchanged");
    // power partition 3, stays clamped
    busWrite(8'h30, 32'h103);
    idle(WAIT_DONE);
    busRead(8'h38, 32'h000A, "R4 two partitions powered");
    checkVec("R9 power-up still clamped", clampOn, 16'hFFFF);
    // R7 swapped bit: bit 4 releases partition 3
    busWrite(8'h34, 32'h10);
    checkVec("R7 swapped release", clampOn, 16'hFFF7);
    // R8 bit 3 maps to partition 4 (off), bit 0 partition 0 (off)
    busWrite(8'h34, 32'h09);
    checkVec("R8 release of unpowered ignored", clampOn, 16'hFFF7);
    // R7 direct mapping for partition 5
    busWrite(8'h30, 32'h105);
    idle(WAIT_DONE);
    busRead(8'h38, 32'h002A, "R4 partition 5 powered");
    busWrite(8'h34, 32'h20);
    checkVec("R7 direct release", clampOn, 16'hFFD7);
    // R9 power-off re-clamps
    busWrite(8'h30, 32'h105);
    checkVec("R9 clamp on power-off", clampOn, 16'hFFF7);
    checkVec("R2 request off", pwrReq, 16'h000A);
    idle(WAIT_DONE);
    busRead(8'h38, 32'h000A, "R4 partition 5 off");
    // R6 stuck switch
    stuck[7] = 1'b1;
    busWrite(8'h30, 32'h107);
    checkVec("R6 request raised", pwrReq, 16'h008A);
    idle(10);
    busRead(8'h38, 32'h000A, "R6 status held while waiting");
    idle(WAIT_DONE);
    checkVec("R6 request withdrawn", pwrReq, 16'h000A);
    busRead(8'h38, 32'h000A, "R6 status after timeout");
    // R6 new commands accepted after timeout
    busWrite(8'h30, 32'h105);
    checkVec("R6 accepted after timeout", pwrReq, 16'h002A);
    idle(WAIT_DONE);
    busRead(8'h38, 32'h002A, "R6 later command completes");
    checkVec("R9 re-powered partition clamped", clampOn, 16'hFFF7);
    idle(4);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule